// File: doc/BRIEF.md
# Reset-Sampled Mode Strap Decoder

This block turns two three-level configuration pins and a line-rate selector into the jitter-attenuator settings of a line interface. The pin levels arrive already decoded as 2-bit codes: 00 means tied low, 01 means floating, and 10 or 11 means tied high. While reset is held, the block reads the pins on every clock. From them it loads three register bits: the attenuator enable, the attenuator path select, and the PLL bandwidth select. The default of the bandwidth select depends on the line rate.

Once reset is released, these three bits are frozen. From then on only the register write port changes them. The same two pins keep live, combinational control of the transmit driver enable and the receive monitor mode. A board can therefore hard-wire the attenuator mode and still toggle the driver and the monitor in the field.

Top module: `strap_mode_ctl`

## Requirements
- R1: Reset is synchronous and active low. At each rising clock edge while `rst_n` is 0, `ja_en`, `ja_rx_path` and `ja_bw` load the values decoded from the current pins. A write is ignored during reset.
- R2: `tx_drv_en` is 0 exactly when `tx_strap` is 00, and 1 for 01, 10 and 11. It follows the pin combinationally at all times.
- R3: `rx_mon_en` is 1 exactly when `mon_strap` is 10 or 11. It follows the pin combinationally at all times.
- R4: If `tx_strap` is 01 at reset, the captured state is `ja_en`=1 with `ja_rx_path`=0, which selects the transmit path.
- R5: If `mon_strap` is 01 and `tx_strap` is not 01 at reset, the captured state is `ja_en`=1 with `ja_rx_path`=1, which selects the receive path.
- R6: If both pins are 01 at reset, the transmit path wins: `ja_en`=1 and `ja_rx_path`=0.
- R7: If neither pin is 01 at reset, the captured state is `ja_en`=0 and `ja_rx_path`=0.
- R8: The captured `ja_bw` is 0 for `rate_sel` 00 (E3) and 01 (DS3), and 1 for 10 (STS-1) and 11.
- R9: After reset, changes on `tx_strap`, `mon_strap` and `rate_sel` leave `ja_en`, `ja_rx_path` and `ja_bw` unchanged unless a write occurs.
- R10: After reset, a cycle with `wr_en`=1 loads `wr_ja_en`, `wr_ja_rx_path` and `wr_ja_bw` into the three bits. The new values appear after that clock edge.
- R11: A later reset discards written values and restores the values decoded from the pins at that time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset; pins are captured while it is low |
| tx_strap | input | 2 | Transmit strap level code (00 low, 01 float, 1x high) |
| mon_strap | input | 2 | Monitor strap level code (00 low, 01 float, 1x high) |
| rate_sel | input | 2 | Line rate: 00 E3, 01 DS3, 1x STS-1 |
| wr_en | input | 1 | Register write strobe |
| wr_ja_en | input | 1 | Write data for attenuator enable |
| wr_ja_rx_path | input | 1 | Write data for path select (1 = receive) |
| wr_ja_bw | input | 1 | Write data for bandwidth select |
| ja_en | output | 1 | Attenuator enable bit |
| ja_rx_path | output | 1 | Attenuator path select, 0 transmit, 1 receive |
| ja_bw | output | 1 | PLL bandwidth select bit |
| tx_drv_en | output | 1 | Live transmit driver enable |
| rx_mon_en | output | 1 | Live receive monitor mode |

## Verification
The bench goes after the case where both pins float at reset. A design with the wrong priority would select the receive path there. It also wiggles the pins and the rate right after reset is released; a design that forgot to freeze the capture would track those changes. A write strobed during reset must lose to the capture, or the design would come out of reset with stale written bits. Code 11 must act as tied high, or the driver and monitor outputs would come out wrong for that encoding.

// File: rtl/strap_pkg.sv
package strap_pkg;
  localparam int LVL_W  = 2;
  localparam int RATE_W = 2;

  typedef enum logic [LVL_W-1:0] {
    LVL_LOW   = 2'b00,
    LVL_FLOAT = 2'b01,
    LVL_HIGH  = 2'b10,
    LVL_HIGH2 = 2'b11
  } lvl_e;

  typedef struct packed {
    logic en;
    logic rx_path;
    logic bw;
  } ja_cfg_t;

  function automatic logic is_float(logic [LVL_W-1:0] lvl);
    return lvl == LVL_FLOAT;
  endfunction

  function automatic logic is_high(logic [LVL_W-1:0] lvl);
    return lvl[LVL_W-1];
  endfunction

  // Wide bandwidth default only for the fastest rate (upper half of codes)
  function automatic logic rate_bw_default(logic [RATE_W-1:0] rate);
    return rate[RATE_W-1];
  endfunction

  // Transmit float has priority over receive float
  function automatic ja_cfg_t pins_to_cfg(logic [LVL_W-1:0] tx,
                                          logic [LVL_W-1:0] mon,
                                          logic [RATE_W-1:0] rate);
    ja_cfg_t c;
    c.en      = is_float(tx) | is_float(mon);
    c.rx_path = is_float(mon) & ~is_float(tx);
    c.bw      = rate_bw_default(rate);
    return c;
  endfunction
endpackage

// File: rtl/strap_capture.sv
module strap_capture
  import strap_pkg::*;
(
  input  logic [LVL_W-1:0]  tx_strap,
  input  logic [LVL_W-1:0]  mon_strap,
  input  logic [RATE_W-1:0] rate_sel,
  output ja_cfg_t           cap_cfg
);
  always_comb cap_cfg = pins_to_cfg(tx_strap, mon_strap, rate_sel);

  always_comb begin
    // R6: a transmit-path request never yields a receive-path selection
    if (tx_strap == LVL_FLOAT)
      a_tx_priority_r6: assert (cap_cfg.en && !cap_cfg.rx_path);
    // R7: no float code means the attenuator is off
    if (tx_strap != LVL_FLOAT && mon_strap != LVL_FLOAT)
      a_no_float_r7: assert (!cap_cfg.en && !cap_cfg.rx_path);
  end
endmodule

// File: rtl/live_ctrl.sv
module live_ctrl
  import strap_pkg::*;
(
  input  logic [LVL_W-1:0] tx_strap,
  input  logic [LVL_W-1:0] mon_strap,
  output logic             tx_drv_en,
  output logic             rx_mon_en
);
  always_comb begin
    tx_drv_en = (tx_strap != LVL_LOW);
    rx_mon_en = is_high(mon_strap);
  end

  always_comb begin
    if (tx_strap == LVL_LOW) a_drv_off_r2: assert (!tx_drv_en);
    if (mon_strap == LVL_FLOAT || mon_strap == LVL_LOW)
      a_mon_off_r3: assert (!rx_mon_en);
  end
endmodule

// File: rtl/cfg_regs.sv
module cfg_regs
  import strap_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  ja_cfg_t cap_cfg,
  input  logic    wr_en,
  input  ja_cfg_t wr_cfg,
  output ja_cfg_t cfg_q
);
  always_ff @(posedge clk) begin
    if (!rst_n)     cfg_q <= cap_cfg;
    else if (wr_en) cfg_q <= wr_cfg;
  end

  // R1: value right after reset release equals capture from the last reset cycle
  p_capture_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(rst_n) |-> cfg_q == $past(cap_cfg));

  // R9: frozen without writes once out of reset
  p_frozen_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && !$past(wr_en)) |-> $stable(cfg_q));

  // R10: write lands on the next edge
  p_write_r10: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> cfg_q == $past(wr_cfg));
endmodule

// File: rtl/strap_mode_ctl.sv
module strap_mode_ctl
  import strap_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [LVL_W-1:0]  tx_strap,
  input  logic [LVL_W-1:0]  mon_strap,
  input  logic [RATE_W-1:0] rate_sel,
  input  logic              wr_en,
  input  logic              wr_ja_en,
  input  logic              wr_ja_rx_path,
  input  logic              wr_ja_bw,
  output logic              ja_en,
  output logic              ja_rx_path,
  output logic              ja_bw,
  output logic              tx_drv_en,
  output logic              rx_mon_en
);
  ja_cfg_t cap_cfg;
  ja_cfg_t wr_cfg;
  ja_cfg_t cfg_q;

  assign wr_cfg = '{en: wr_ja_en, rx_path: wr_ja_rx_path, bw: wr_ja_bw};

  strap_capture u_cap (
    .tx_strap (tx_strap),
    .mon_strap(mon_strap),
    .rate_sel (rate_sel),
    .cap_cfg  (cap_cfg)
  );

  cfg_regs u_regs (
    .clk    (clk),
    .rst_n  (rst_n),
    .cap_cfg(cap_cfg),
    .wr_en  (wr_en),
    .wr_cfg (wr_cfg),
    .cfg_q  (cfg_q)
  );

  live_ctrl u_live (
    .tx_strap (tx_strap),
    .mon_strap(mon_strap),
    .tx_drv_en(tx_drv_en),
    .rx_mon_en(rx_mon_en)
  );

  assign ja_en      = cfg_q.en;
  assign ja_rx_path = cfg_q.rx_path;
  assign ja_bw      = cfg_q.bw;
endmodule

// File: tb/tb_strap_mode_ctl.sv
`timescale 1ns/1ps
module tb_strap_mode_ctl;
  logic clk = 0;
  logic rst_n = 0;
  logic [1:0] tx_strap = 0, mon_strap = 0, rate_sel = 0;
  logic wr_en = 0, wr_ja_en = 0, wr_ja_rx_path = 0, wr_ja_bw = 0;
  logic ja_en, ja_rx_path, ja_bw, tx_drv_en, rx_mon_en;
  int n_tests = 0, n_fail = 0;
  int seed = 1234;

  always #2.5 clk = ~clk;

  strap_mode_ctl dut (.*);

  // expected {en, rx_path, bw} from the requirement tables
  function automatic logic [2:0] exp_cap(logic [1:0] t, logic [1:0] m, logic [1:0] r);
    logic e, p, b;
    case ({t == 2'b01, m == 2'b01})
      2'b10, 2'b11: begin e = 1; p = 0; end   // R4, R6
      2'b01:        begin e = 1; p = 1; end   // R5
      default:      begin e = 0; p = 0; end   // R7
    endcase
    b = (r == 2'b10 || r == 2'b11);           // R8
    return {e, p, b};
  endfunction

  task automatic chk(string req, logic [2:0] act, logic [2:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %b expected %b", req, act, exp);
    end
  endtask

  task automatic chk_live(string req);
    chk(req, {1'b0, tx_drv_en, rx_mon_en},
        {1'b0, tx_strap != 2'b00, mon_strap[1]});
  endtask

  task automatic do_reset(logic [1:0] t, logic [1:0] m, logic [1:0] r, logic wr_noise);
    @(negedge clk);
    rst_n = 0; tx_strap = t; mon_strap = m; rate_sel = r;
    wr_en = wr_noise; wr_ja_en = ~exp_cap(t, m, r)[2];
    wr_ja_rx_path = ~exp_cap(t, m, r)[1]; wr_ja_bw = ~exp_cap(t, m, r)[0];
    repeat (2) @(negedge clk);
    chk("R1 capture in reset", {ja_en, ja_rx_path, ja_bw}, exp_cap(t, m, r));
    rst_n = 1; wr_en = 0;
    @(negedge clk);
    chk("R11 captured after release", {ja_en, ja_rx_path, ja_bw}, exp_cap(t, m, r));
  endtask

  initial begin
    #(200000 * 5);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    logic [2:0] held;
    void'($urandom(seed));
    // directed corners
    do_reset(2'b01, 2'b01, 2'b00, 1'b0);
    chk("R6 both float", {ja_en, ja_rx_path, 1'b0}, 3'b100);
    do_reset(2'b00, 2'b01, 2'b01, 1'b1);
    chk("R5 rx float", {ja_en, ja_rx_path, ja_bw}, 3'b110);
    do_reset(2'b01, 2'b10, 2'b10, 1'b0);
    chk("R4 tx float", {ja_en, ja_rx_path, ja_bw}, 3'b101);
    do_reset(2'b11, 2'b11, 2'b11, 1'b1);
    chk("R7 no float", {ja_en, ja_rx_path, ja_bw}, 3'b001);
    chk_live("R2 R3 code 11");
    do_reset(2'b10, 2'b00, 2'b01, 1'b0);
    chk("R8 DS3 bw", {2'b00, ja_bw}, 3'b000);

    for (int i = 0; i < 60; i++) begin
      logic [1:0] t, m, r;
      t = 2'($urandom); m = 2'($urandom); r = 2'($urandom);
      do_reset(t, m, r, 1'($urandom));
      held = exp_cap(t, m, r);
      for (int k = 0; k < 4; k++) begin
        @(negedge clk);
        tx_strap = 2'($urandom); mon_strap = 2'($urandom); rate_sel = 2'($urandom);
        #1;
        chk_live("R2 R3 live pins");
        @(negedge clk);
        chk("R9 frozen after reset", {ja_en, ja_rx_path, ja_bw}, held);
      end
      @(negedge clk);
      wr_en = 1; held = 3'($urandom);
      {wr_ja_en, wr_ja_rx_path, wr_ja_bw} = held;
      @(negedge clk);
      wr_en = 0;
      chk("R10 write", {ja_en, ja_rx_path, ja_bw}, held);
      @(negedge clk);
      chk("R9 hold written", {ja_en, ja_rx_path, ja_bw}, held);
    end
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule